// File: doc/BRIEF.md
# Sequential Hopfield Recall Engine

This block recovers a stored binary pattern from a noisy or partial probe. It models a fully connected network of N two-state neurons. It reads a fixed weight set from an external weight store through a row/column read port. A one-cycle capture strobe latches an N-bit probe. The engine then updates the neurons one at a time, in ascending index order. Each neuron reads its weight row one entry per cycle. Each weighted term is formed by choosing between the weight and its negation, so no multiplier is needed. The neuron's new state is the complement of the sign bit of the accumulated sum.

Full passes over all neurons, called epochs, repeat until a pass changes nothing. At that point `done_o` rises and `pattern_o` holds the recalled pattern. A pattern that keeps cycling is stopped after a parameterised number of epochs, and `timeout_o` is raised instead.

The controller has six states.
- IDLE waits for capture and moves to ADMIT.
- ADMIT copies the latched probe into the state register and moves to SNAP.
- SNAP stores the epoch-start snapshot, clears the sum and indices, and moves to ACC.
- ACC accumulates one term per cycle. It stays in ACC until the last column, then moves to WRITE.
- WRITE stores one neuron's new state. It returns to ACC for the next neuron, or moves to EPEND after the last neuron.
- EPEND compares the state with the snapshot. It moves to IDLE on a match (converged) or when the epoch limit is reached (timeout). Otherwise it moves back to SNAP.

Top module: `hopfield_recall`

## Requirements
- R1: After reset, `done_o` and `timeout_o` are 0 and `pattern_o` is all zeros.
- R2: A capture in IDLE registers `probe_i`. That value enters the state register only in the ADMIT cycle. Later changes to `probe_i` have no effect on the run.
- R3: The sum for neuron i is the sum, over every j not equal to i, of +w(i,j) when state bit j is 1 and −w(i,j) when it is 0. The diagonal weight is ignored. The sum is exact for any two's complement weight of WW bits.
- R4: A neuron's new state bit is 1 when its sum is zero or positive, and 0 when it is negative. Bit value 1 encodes +1 and bit value 0 encodes −1.
- R5: Neurons are updated in ascending index order. Each update uses the already-updated bits of lower-indexed neurons. At most one state bit changes per update.
- R6: When an epoch leaves the state unchanged, `done_o` rises, `timeout_o` stays 0, and `pattern_o` holds the final state. That output stays stable while the engine is idle.
- R7: When MAX_EPOCHS epochs all change the state, `timeout_o` rises and `done_o` stays 0.
- R8: A capture strobe while a run is in progress is ignored.
- R9: `done_o` and `timeout_o` are both low from the capture edge until the run ends.
- R10: With E epochs executed, the flag is visible 1 + E·(N·N + N + 2) clock edges after the capture edge. During neuron i's accumulation, the read port addresses row i, and the column steps from 0 to N−1, one column per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| capture_i | input | 1 | Start strobe, honoured only in IDLE |
| probe_i | input | N | Probe pattern, bit 1 = +1 |
| w_row_o | output | $clog2(N) | Weight store row address (neuron being updated) |
| w_col_o | output | $clog2(N) | Weight store column address (source neuron) |
| w_data_i | input | WW | Weight read back, two's complement, same cycle |
| done_o | output | 1 | Converged, pattern valid |
| timeout_o | output | 1 | Epoch limit reached without convergence |
| pattern_o | output | N | Current or recalled state |

## Verification
The hardest situation to reach from the ports is the epoch-limit exit. A symmetric weight set always converges, so that exit never occurs with one. The stimulus therefore loads an asymmetric ring of negative couplings, under which most probes keep shifting from epoch to epoch. A second hard corner is the sum at its extreme magnitude. A weight set of all most-negative entries drives the sum to its full range. That set also places non-zero values on the diagonal, to show they are excluded. A capture strobe is also injected mid-run, and the probe is flipped right after every capture, to show that neither disturbs the run.

// File: rtl/hr_pkg.sv
package hr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADMIT,
        ST_SNAP,
        ST_ACC,
        ST_WRITE,
        ST_EPEND
    } hr_state_t;
endpackage

// File: rtl/hr_term_sel.sv
module hr_term_sel #(
    parameter int WW = 4,
    parameter int SW = 7
) (
    input  logic signed [WW-1:0] w_i,
    input  logic                 pos_i,
    output logic signed [SW-1:0] term_o
);
    logic signed [SW-1:0] ext;

    assign ext    = {{(SW-WW){w_i[WW-1]}}, w_i};
    // choose +w or -w by the source neuron's state
    assign term_o = pos_i ? ext : -ext;
endmodule

// File: rtl/hr_accum.sv
module hr_accum #(
    parameter int SW = 7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr_i,
    input  logic                 en_i,
    input  logic signed [SW-1:0] term_i,
    output logic signed [SW-1:0] sum_o
);
    logic signed [SW-1:0] sum_q;
    logic signed [SW-1:0] nxt;

    assign nxt   = sum_q + term_i;
    assign sum_o = sum_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            sum_q <= '0;
        end else if (en_i) begin
            sum_q <= nxt;
        end
    end

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        en_i && !clr_i |-> !((sum_q[SW-1] == term_i[SW-1]) && (nxt[SW-1] != sum_q[SW-1])));
endmodule

// File: rtl/hopfield_recall.sv
module hopfield_recall
    import hr_pkg::*;
#(
    parameter int N          = 8,
    parameter int WW         = 4,
    parameter int MAX_EPOCHS = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    capture_i,
    input  logic [N-1:0]            probe_i,
    output logic [$clog2(N)-1:0]    w_row_o,
    output logic [$clog2(N)-1:0]    w_col_o,
    input  logic signed [WW-1:0]    w_data_i,
    output logic                    done_o,
    output logic                    timeout_o,
    output logic [N-1:0]            pattern_o
);
    localparam int IW     = $clog2(N);
    localparam int MAXMAG = (N - 1) * (1 << (WW - 1));
    localparam int SW     = $clog2(MAXMAG + 1) + 1;
    localparam int EPW    = $clog2(MAX_EPOCHS + 1);
    localparam logic [IW-1:0]  LAST_IDX = IW'(N - 1);
    localparam logic [EPW-1:0] LAST_EP  = EPW'(MAX_EPOCHS - 1);

    hr_state_t st_q, st_d;

    logic [N-1:0]         pat_q;
    logic [N-1:0]         rin_q;
    logic [N-1:0]         snap_q;
    logic [IW-1:0]        i_q;
    logic [IW-1:0]        j_q;
    logic [EPW-1:0]       epoch_q;
    logic                 done_q;
    logic                 to_q;
    logic signed [SW-1:0] term;
    logic signed [SW-1:0] sum;
    logic                 acc_en;
    logic                 acc_clr;

    assign acc_en  = (st_q == ST_ACC) && (j_q != i_q);
    assign acc_clr = (st_q == ST_SNAP) || (st_q == ST_WRITE);

    hr_term_sel #(.WW(WW), .SW(SW)) term_i (
        .w_i    (w_data_i),
        .pos_i  (pat_q[j_q]),
        .term_o (term)
    );

    hr_accum #(.SW(SW)) accum_i (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (acc_clr),
        .en_i   (acc_en),
        .term_i (term),
        .sum_o  (sum)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (capture_i) st_d = ST_ADMIT;
            ST_ADMIT: st_d = ST_SNAP;
            ST_SNAP:  st_d = ST_ACC;
            ST_ACC:   if (j_q == LAST_IDX) st_d = ST_WRITE;
            ST_WRITE: st_d = (i_q == LAST_IDX) ? ST_EPEND : ST_ACC;
            ST_EPEND: st_d = ((pat_q == snap_q) || (epoch_q == LAST_EP)) ? ST_IDLE : ST_SNAP;
            default:  st_d = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            pat_q   <= '0;
            rin_q   <= '0;
            snap_q  <= '0;
            i_q     <= '0;
            j_q     <= '0;
            epoch_q <= '0;
            done_q  <= 1'b0;
            to_q    <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (capture_i) begin
                        rin_q   <= probe_i;
                        done_q  <= 1'b0;
                        to_q    <= 1'b0;
                        epoch_q <= '0;
                    end
                end
                ST_ADMIT: pat_q <= rin_q;
                ST_SNAP: begin
                    snap_q <= pat_q;
                    i_q    <= '0;
                    j_q    <= '0;
                end
                ST_ACC: j_q <= (j_q == LAST_IDX) ? '0 : j_q + 1'b1;
                ST_WRITE: begin
                    pat_q[i_q] <= ~sum[SW-1];
                    i_q        <= (i_q == LAST_IDX) ? '0 : i_q + 1'b1;
                    j_q        <= '0;
                end
                ST_EPEND: begin
                    if (pat_q == snap_q)        done_q  <= 1'b1;
                    else if (epoch_q == LAST_EP) to_q   <= 1'b1;
                    else                        epoch_q <= epoch_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign w_row_o   = i_q;
    assign w_col_o   = j_q;
    assign done_o    = done_q;
    assign timeout_o = to_q;
    assign pattern_o = pat_q;

    // R9
    busy_flag_low_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q != ST_IDLE) |-> (!done_o && !timeout_o));

    // R2
    admit_only_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q != ST_ADMIT && st_q != ST_WRITE) |=> $stable(pat_q));

    // R5
    single_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_WRITE) |=> ($countones(pat_q ^ $past(pat_q)) <= 1));

    // R7
    flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done_o && timeout_o));

    // R7
    epoch_bound_chk: assert property (@(posedge clk) disable iff (rst)
        epoch_q <= LAST_EP);
endmodule

// File: tb/hopfield_recall_tb_top.sv
module hopfield_recall_tb_top;
    localparam int N  = 8;
    localparam int WW = 4;
    localparam int ME = 6;
    localparam int IW = $clog2(N);

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 capture_i = 1'b0;
    logic [N-1:0]         probe_i = '0;
    logic [IW-1:0]        w_row, w_col;
    logic signed [WW-1:0] w_data;
    logic                 done_o, timeout_o;
    logic [N-1:0]         pattern_o;

    int wm [N][N];
    int checks = 0;
    int failures = 0;
    int gcyc = 0;

    always #2 clk = ~clk;

    assign w_data = WW'(wm[w_row][w_col]);

    hopfield_recall #(.N(N), .WW(WW), .MAX_EPOCHS(ME)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .capture_i (capture_i),
        .probe_i   (probe_i),
        .w_row_o   (w_row),
        .w_col_o   (w_col),
        .w_data_i  (w_data),
        .done_o    (done_o),
        .timeout_o (timeout_o),
        .pattern_o (pattern_o)
    );

    always @(posedge clk) begin
        gcyc <= gcyc + 1;
        if (gcyc >= 190000) begin
            failures = failures + 1;
            checks = checks + 1;
            $display("FAIL watchdog: act=%0d exp<%0d", gcyc, 190000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // reference: R3 R4 R5 R6 R7
    task automatic model(input logic [N-1:0] pr, output logic [N-1:0] res,
                         output int ep, output bit tmo);
        logic [N-1:0] s;
        logic [N-1:0] snap;
        s = pr;
        tmo = 1'b1;
        ep = ME;
        for (int e = 1; e <= ME; e++) begin
            snap = s;
            for (int i = 0; i < N; i++) begin
                int acc;
                acc = 0;
                for (int j = 0; j < N; j++)
                    if (j != i) acc += s[j] ? wm[i][j] : -wm[i][j];
                s[i] = (acc >= 0);
            end
            if (s == snap) begin
                tmo = 1'b0;
                ep = e;
                break;
            end
        end
        res = s;
    endtask

    task automatic run_one(input logic [N-1:0] pr, input int inj);
        logic [N-1:0] exp_pat;
        int exp_ep;
        bit exp_to;
        int cyc;
        bit early;
        model(pr, exp_pat, exp_ep, exp_to);
        @(negedge clk);
        probe_i = pr;
        capture_i = 1'b1;
        @(negedge clk);
        capture_i = 1'b0;
        probe_i = ~pr;   // R2: must be ignored
        cyc = 1;
        chk(!done_o && !timeout_o, "R9 flags low after capture", {done_o, timeout_o}, 0);
        early = 1'b0;
        while (!(done_o || timeout_o) && cyc < 3000) begin
            if (cyc == inj) begin
                capture_i = 1'b1;           // R8
                probe_i = pr ^ 8'h5A;
            end else begin
                capture_i = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        capture_i = 1'b0;
        chk(cyc < 3000, "R9 run ends", cyc, 3000);
        chk(pattern_o == exp_pat, inj > 0 ? "R8 pattern" : "R3/R4/R5 pattern", pattern_o, exp_pat);
        chk(done_o == !exp_to, exp_to ? "R7 done low" : "R6 done", done_o, !exp_to);
        chk(timeout_o == exp_to, exp_to ? "R7 timeout" : "R6 timeout low", timeout_o, exp_to);
        chk(cyc == 2 + exp_ep * (N*N + N + 2), "R10 latency", cyc, 2 + exp_ep * (N*N + N + 2));
        repeat (3) @(negedge clk);
        chk(pattern_o == exp_pat, "R6 hold", pattern_o, exp_pat);
    endtask

    function automatic int bip(input logic b);
        return b ? 1 : -1;
    endfunction

    initial begin
        logic [N-1:0] p1, p2;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(done_o == 0, "R1 done", done_o, 0);
        chk(timeout_o == 0, "R1 timeout", timeout_o, 0);
        chk(pattern_o == 0, "R1 pattern", pattern_o, 0);

        // Hebbian set of two patterns, full probe sweep
        p1 = 8'hCA;
        p2 = 8'h0F;
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                wm[i][j] = (i == j) ? 0 : bip(p1[i])*bip(p1[j]) + bip(p2[i])*bip(p2[j]);
        for (int v = 0; v < 256; v++) run_one(N'(v), 0);
        run_one(8'h3C, 30);   // R8 mid-run capture
        run_one(8'hC3, 200);

        // extreme weights, nonzero diagonal ignored (R3)
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                wm[i][j] = (i == j) ? 7 : -8;
        for (int v = 0; v < 32; v++) run_one(N'(v * 7 + 1), 0);
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                wm[i][j] = (i == j) ? -5 : (((i + j) * 5 + i * j) % 16) - 8;
        for (int v = 0; v < 48; v++) run_one(N'(v * 5 + 3), 0);

        // asymmetric ring: cycling patterns reach the epoch limit (R7)
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                wm[i][j] = (j == (i + 1) % N) ? -1 : 0;
        for (int v = 0; v < 16; v++) run_one(N'(v * 17), 0);
        run_one(8'h55, 0);
        run_one(8'hFF, 40);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule